// File: doc/BRIEF.md
# Memory Card Command Issue Unit

This block issues a single command to a memory card and captures what the card answers. The host loads a 32-bit argument and then writes an 11-bit command word. That word carries a 6-bit command index and five control bits. When the word's enable bit is set, the unit presents the index and a snapshot of the argument on a card-side request handshake. It then decides, from the byte count the card reports, whether the answer is acceptable. Any returned bytes are absorbed. An acceptable answer is packed into four 32-bit response words.

Each issued command ends in exactly one sticky outcome flag: response received, sent without a response, or timeout. At the same moment the unit drops its busy indication and clears the enable bit in the stored command word. A command marked as pending is never sent to the card. Bit-level serial framing and checksum generation on the command line belong to a neighbouring block. The card side here is a transaction-level handshake.

Top module: `cmd_issue_unit`

## Requirements
- R1: A command-word write while `cmd_active` is low is stored in `cmd_word`. If bit 10 (enable) is set and bit 9 (pending) is clear, `cmd_active` and `card_req` rise after the accepting edge, with `card_index` equal to bits [5:0] and `card_arg` equal to the argument last written. Both are held until `card_ack`. A write with bit 10 clear raises no request.
- R2: When bit 6 (response wanted) is clear and `card_err` is low at ack, the outcome is status bit 1 (sent), whatever `card_len` is, and `resp_words` is left unchanged.
- R3: When bit 6 is set, bit 7 (long) is clear and the card reports 4 bytes, the outcome is status bit 0. Word 0 (`resp_words[31:0]`) holds the four bytes with the first byte in bits [31:24], and words 1 to 3 read zero.
- R4: When bit 6 is set and the card reports 16 bytes, the outcome is status bit 0. Word n (`resp_words[32n+31:32n]`) holds bytes 4n..4n+3, first byte most significant, and bit 0 of word 3 (`resp_words[96]`) is forced to zero.
- R5: The outcome is status bit 2 (timeout), with `resp_words` unchanged, when `card_err` is high at ack, or when bit 6 is set and the card reports 0 bytes, 4 bytes with bit 7 set, or any count other than 4 or 16.
- R6: A command word with bits 10 and 9 both set raises no request and no status flag. Its enable bit reads back cleared two edges after the write.
- R7: The edge that sets an outcome flag also lowers `cmd_active` and clears bit 10 of `cmd_word`.
- R8: Command-word writes made while `cmd_active` is high are ignored and start no further request.
- R9: Status flags are sticky until a clear write, which drops the flags selected in `clr_bits`. A flag being set in the same edge as a clear of it ends up set.
- R10: Each issued command sets exactly one outcome flag.
- R11: After reset, `status`, `resp_words`, `cmd_word`, `cmd_active` and `card_req` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_we | input | 1 | Argument write strobe |
| arg_wdata | input | 32 | Argument value |
| cw_we | input | 1 | Command-word write strobe |
| cw_wdata | input | 11 | Command word: [5:0] index, 6 want response, 7 long, 8 interrupt mode, 9 pending, 10 enable |
| clr_we | input | 1 | Status clear strobe |
| clr_bits | input | 3 | Flags to clear: 0 response, 1 sent, 2 timeout |
| card_req | output | 1 | Request to the card side, held until ack |
| card_index | output | 6 | Command index of the request |
| card_arg | output | 32 | Argument of the request |
| card_ack | input | 1 | Card-side acknowledge, one cycle |
| card_err | input | 1 | Card-side error, valid with ack |
| card_len | input | 5 | Response byte count, valid with ack |
| card_byte_vld | input | 1 | Response byte strobe, after ack |
| card_byte | input | 8 | Response byte |
| cmd_word | output | 11 | Stored command word |
| cmd_active | output | 1 | Command being handled |
| status | output | 3 | Sticky outcome flags: 0 response, 1 sent, 2 timeout |
| resp_words | output | 128 | Four response words, word n at [32n+31:32n] |

## Verification
Two functions can land on one edge: a host write to the status-clear port, and the completion of a command setting its outcome flag. The bench forces this by leaving an older flag set and then pulsing a clear of all three flags on the very cycle that the card delivers the last response byte. It expects the older flag to be gone and the new outcome flag to survive. A second overlap is a command-word write made while a response is streaming in. It is judged by the stored word after completion and by the absence of a second request.

// File: rtl/cmd_issue_pkg.sv
package cmd_issue_pkg;

    localparam int CW_W   = 11;
    localparam int IDX_W  = 6;
    localparam int BYTE_W = 8;
    localparam int WORD_W = 32;
    localparam int ST_W   = 3;
    localparam int SHORT_BYTES = WORD_W / BYTE_W;

    localparam int ST_RESP = 0;
    localparam int ST_SENT = 1;
    localparam int ST_TMO  = 2;

    typedef struct packed {
        logic             enable;
        logic             pending;
        logic             irq_mode;
        logic             long_rsp;
        logic             want_rsp;
        logic [IDX_W-1:0] index;
    } cmd_word_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_ASK,
        SQ_TAKE
    } seq_state_e;

    typedef enum logic [1:0] {
        VD_TIMEOUT,
        VD_SENT,
        VD_SHORT,
        VD_LONG
    } verdict_e;

    function automatic verdict_e judge(input logic err, input logic want,
                                       input logic lng, input int unsigned n,
                                       input int unsigned long_n);
        verdict_e v;
        if (err)                            v = VD_TIMEOUT;
        else if (!want)                     v = VD_SENT;
        else if (n == SHORT_BYTES && !lng)  v = VD_SHORT;
        else if (n == long_n)               v = VD_LONG;
        else                                v = VD_TIMEOUT;
        return v;
    endfunction

    function automatic logic [ST_W-1:0] verdict_flag(input verdict_e v);
        logic [ST_W-1:0] f;
        f = '0;
        case (v)
            VD_SHORT, VD_LONG: f[ST_RESP] = 1'b1;
            VD_SENT:           f[ST_SENT] = 1'b1;
            default:           f[ST_TMO]  = 1'b1;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/cmd_seq.sv
module cmd_seq
    import cmd_issue_pkg::*;
#(
    parameter int ARG_W      = 32,
    parameter int LEN_W      = 5,
    parameter int LONG_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              arg_we,
    input  logic [ARG_W-1:0]  arg_wdata,
    input  logic              cw_we,
    input  logic [CW_W-1:0]   cw_wdata,
    input  logic              card_ack,
    input  logic              card_err,
    input  logic [LEN_W-1:0]  card_len,
    input  logic              card_byte_vld,
    output logic              card_req,
    output logic [IDX_W-1:0]  card_index,
    output logic [ARG_W-1:0]  card_arg,
    output logic [CW_W-1:0]   cmd_word,
    output logic              cmd_active,
    output logic              byte_take,
    output logic              finish,
    output verdict_e          verdict
);

    seq_state_e       state;
    cmd_word_t        cw_q;
    cmd_word_t        cw_in;
    logic [ARG_W-1:0] arg_q;
    logic [ARG_W-1:0] arg_snap;
    logic [LEN_W-1:0] remain;
    verdict_e         verdict_q;
    verdict_e         verdict_now;
    logic             ask_done;
    logic             take_done;

    always_comb begin
        cw_in       = cmd_word_t'(cw_wdata);
        verdict_now = judge(card_err, cw_q.want_rsp, cw_q.long_rsp,
                            int'(unsigned'(card_len)), LONG_BYTES);
        ask_done    = (state == SQ_ASK) && card_ack &&
                      (card_err || (card_len == '0));
        take_done   = (state == SQ_TAKE) && card_byte_vld &&
                      (remain == LEN_W'(1));
        finish      = ask_done || take_done;
        byte_take   = (state == SQ_TAKE) && card_byte_vld;
        verdict     = (state == SQ_ASK) ? verdict_now : verdict_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cw_q      <= '0;
            arg_q     <= '0;
            arg_snap  <= '0;
            remain    <= '0;
            verdict_q <= VD_TIMEOUT;
        end else begin
            if (arg_we) arg_q <= arg_wdata;
            case (state)
                SQ_IDLE: begin
                    if (cw_we) begin
                        cw_q <= cw_in;
                        if (cw_in.enable) begin
                            arg_snap <= arg_q;
                            state    <= cw_in.pending ? SQ_HOLD : SQ_ASK;
                        end
                    end
                end
                SQ_HOLD: begin
                    cw_q.enable <= 1'b0;
                    state       <= SQ_IDLE;
                end
                SQ_ASK: begin
                    if (card_ack) begin
                        if (ask_done) begin
                            cw_q.enable <= 1'b0;
                            state       <= SQ_IDLE;
                        end else begin
                            remain    <= card_len;
                            verdict_q <= verdict_now;
                            state     <= SQ_TAKE;
                        end
                    end
                end
                SQ_TAKE: begin
                    if (card_byte_vld) begin
                        remain <= remain - LEN_W'(1);
                        if (take_done) begin
                            cw_q.enable <= 1'b0;
                            state       <= SQ_IDLE;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    assign card_req   = (state == SQ_ASK);
    assign card_index = cw_q.index;
    assign card_arg   = arg_snap;
    assign cmd_word   = cw_q;
    assign cmd_active = (state != SQ_IDLE);

endmodule

// File: rtl/resp_shift.sv
module resp_shift
    import cmd_issue_pkg::*;
#(
    parameter int RESP_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         byte_take,
    input  logic [BYTE_W-1:0]            byte_in,
    input  logic                         finish,
    input  verdict_e                     verdict,
    output logic [RESP_WORDS*WORD_W-1:0] resp
);

    localparam int SH_W = RESP_WORDS * WORD_W;

    logic [SH_W-1:0] sh;
    logic [SH_W-1:0] nxt;
    logic [SH_W-1:0] packed_w;
    logic            commit;

    always_comb begin
        nxt = byte_take ? {sh[SH_W-BYTE_W-1:0], byte_in} : sh;
    end

    always_comb begin
        packed_w = '0;
        if (verdict == VD_SHORT) begin
            packed_w[WORD_W-1:0] = nxt[WORD_W-1:0];
        end else begin
            for (int w = 0; w < RESP_WORDS; w++) begin
                packed_w[w*WORD_W +: WORD_W] = nxt[(RESP_WORDS-1-w)*WORD_W +: WORD_W];
            end
            packed_w[(RESP_WORDS-1)*WORD_W] = 1'b0;
        end
        commit = finish && ((verdict == VD_SHORT) || (verdict == VD_LONG));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '0;
            resp <= '0;
        end else begin
            sh <= nxt;
            if (commit) resp <= packed_w;
        end
    end

endmodule

// File: rtl/status_flags.sv
module status_flags
    import cmd_issue_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            finish,
    input  verdict_e        verdict,
    input  logic            clr_we,
    input  logic [ST_W-1:0] clr_bits,
    output logic [ST_W-1:0] flags
);

    logic [ST_W-1:0] set_v;
    logic [ST_W-1:0] clr_v;

    always_comb begin
        set_v = finish ? verdict_flag(verdict) : '0;
        clr_v = clr_we ? clr_bits : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) flags <= '0;
        else     flags <= (flags & ~clr_v) | set_v;
    end

endmodule

// File: rtl/cmd_issue_unit.sv
module cmd_issue_unit
    import cmd_issue_pkg::*;
#(
    parameter int ARG_W      = 32,
    parameter int LEN_W      = 5,
    parameter int RESP_WORDS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         arg_we,
    input  logic [ARG_W-1:0]             arg_wdata,
    input  logic                         cw_we,
    input  logic [CW_W-1:0]              cw_wdata,
    input  logic                         clr_we,
    input  logic [ST_W-1:0]              clr_bits,
    output logic                         card_req,
    output logic [IDX_W-1:0]             card_index,
    output logic [ARG_W-1:0]             card_arg,
    input  logic                         card_ack,
    input  logic                         card_err,
    input  logic [LEN_W-1:0]             card_len,
    input  logic                         card_byte_vld,
    input  logic [BYTE_W-1:0]            card_byte,
    output logic [CW_W-1:0]              cmd_word,
    output logic                         cmd_active,
    output logic [ST_W-1:0]              status,
    output logic [RESP_WORDS*WORD_W-1:0] resp_words
);

    localparam int LONG_BYTES = RESP_WORDS * (WORD_W / BYTE_W);

    logic     byte_take;
    logic     finish;
    verdict_e verdict;

    cmd_seq #(
        .ARG_W      (ARG_W),
        .LEN_W      (LEN_W),
        .LONG_BYTES (LONG_BYTES)
    ) u_seq (
        .clk           (clk),
        .rst           (rst),
        .arg_we        (arg_we),
        .arg_wdata     (arg_wdata),
        .cw_we         (cw_we),
        .cw_wdata      (cw_wdata),
        .card_ack      (card_ack),
        .card_err      (card_err),
        .card_len      (card_len),
        .card_byte_vld (card_byte_vld),
        .card_req      (card_req),
        .card_index    (card_index),
        .card_arg      (card_arg),
        .cmd_word      (cmd_word),
        .cmd_active    (cmd_active),
        .byte_take     (byte_take),
        .finish        (finish),
        .verdict       (verdict)
    );

    resp_shift #(
        .RESP_WORDS (RESP_WORDS)
    ) u_resp (
        .clk       (clk),
        .rst       (rst),
        .byte_take (byte_take),
        .byte_in   (card_byte),
        .finish    (finish),
        .verdict   (verdict),
        .resp      (resp_words)
    );

    status_flags u_stat (
        .clk      (clk),
        .rst      (rst),
        .finish   (finish),
        .verdict  (verdict),
        .clr_we   (clr_we),
        .clr_bits (clr_bits),
        .flags    (status)
    );

endmodule

// File: rtl/cmd_issue_chk.sv
module cmd_issue_chk #(
    parameter int ARG_W  = 32,
    parameter int RESP_W = 128
) (
    input logic              clk,
    input logic              rst,
    input logic              cw_we,
    input logic              card_req,
    input logic              card_ack,
    input logic              card_byte_vld,
    input logic [ARG_W-1:0]  card_arg,
    input logic [5:0]        card_index,
    input logic [10:0]       cmd_word,
    input logic              cmd_active,
    input logic [2:0]        status,
    input logic [RESP_W-1:0] resp_words
);

    // R1
    req_in_active_chk: assert property (@(posedge clk) disable iff (rst)
        card_req |-> cmd_active);

    // R1
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        card_req && !card_ack |=> card_req && $stable(card_arg) && $stable(card_index));

    // R10
    single_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $countones({$rose(status[0]), $rose(status[1]), $rose(status[2])}) <= 1);

    // R7
    enable_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cmd_active) |-> !cmd_word[10]);

    // R7
    outcome_idle_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(status[0]) || $rose(status[1]) || $rose(status[2])) |-> !cmd_active);

    // R8
    busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
        cmd_active && cw_we && !cmd_word[9] && !card_ack && !card_byte_vld |=> $stable(cmd_word));

    // R4
    last_bit_low_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(status[0]) |-> !resp_words[RESP_W-32]);

endmodule

bind cmd_issue_unit cmd_issue_chk #(
    .ARG_W  (ARG_W),
    .RESP_W (RESP_WORDS*32)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .cw_we         (cw_we),
    .card_req      (card_req),
    .card_ack      (card_ack),
    .card_byte_vld (card_byte_vld),
    .card_arg      (card_arg),
    .card_index    (card_index),
    .cmd_word      (cmd_word),
    .cmd_active    (cmd_active),
    .status        (status),
    .resp_words    (resp_words)
);

// File: tb/sim_cmd_issue_unit.sv
module sim_cmd_issue_unit;

    localparam logic [10:0] EN   = 11'h400;
    localparam logic [10:0] PEND = 11'h200;
    localparam logic [10:0] LNG  = 11'h080;
    localparam logic [10:0] RSP  = 11'h040;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         arg_we = 1'b0;
    logic [31:0]  arg_wdata = '0;
    logic         cw_we = 1'b0;
    logic [10:0]  cw_wdata = '0;
    logic         clr_we = 1'b0;
    logic [2:0]   clr_bits = '0;
    logic         card_req;
    logic [5:0]   card_index;
    logic [31:0]  card_arg;
    logic         card_ack = 1'b0;
    logic         card_err = 1'b0;
    logic [4:0]   card_len = '0;
    logic         card_byte_vld = 1'b0;
    logic [7:0]   card_byte = '0;
    logic [10:0]  cmd_word;
    logic         cmd_active;
    logic [2:0]   status;
    logic [127:0] resp_words;

    typedef struct {
        logic [2:0]   st;
        logic [127:0] rsp;
        logic [10:0]  cw;
        string        tag;
    } exp_t;

    exp_t         q[$];
    logic [2:0]   model_st = '0;
    logic [127:0] model_rsp = '0;
    int           n_vec = 0;
    int           n_bad = 0;
    bit           done = 1'b0;
    bit           was_act = 1'b0;

    always #4 clk = ~clk;

    cmd_issue_unit u0 (
        .clk(clk), .rst(rst), .arg_we(arg_we), .arg_wdata(arg_wdata),
        .cw_we(cw_we), .cw_wdata(cw_wdata), .clr_we(clr_we), .clr_bits(clr_bits),
        .card_req(card_req), .card_index(card_index), .card_arg(card_arg),
        .card_ack(card_ack), .card_err(card_err), .card_len(card_len),
        .card_byte_vld(card_byte_vld), .card_byte(card_byte),
        .cmd_word(cmd_word), .cmd_active(cmd_active), .status(status),
        .resp_words(resp_words)
    );

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    // monitor: compares results as each command finishes
    always @(negedge clk) begin
        if (!rst) begin
            if (was_act && !cmd_active) begin
                if (q.size() == 0) begin
                    check(1'b0, "R10 unexpected completion", 128'(status), 128'(0));
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(status === e.st, {e.tag, " status"}, 128'(status), 128'(e.st));
                    check(resp_words === e.rsp, {e.tag, " response"}, resp_words, e.rsp);
                    check(cmd_word === e.cw, {e.tag, " R7 cmd word"}, 128'(cmd_word), 128'(e.cw));
                end
            end
            was_act = cmd_active;
        end
    end

    task automatic clear_all(input logic [2:0] bits);
        clr_we = 1'b1; clr_bits = bits;
        @(negedge clk);
        clr_we = 1'b0; clr_bits = '0;
        model_st = model_st & ~bits;
    endtask

    task automatic run_cmd(input logic [10:0] cw, input logic [31:0] arg, input bit err,
                           input int len, input logic [7:0] base, input bit poke,
                           input bit clr_hit, input string tag);
        exp_t         e;
        logic [127:0] er;
        logic [2:0]   nb;
        bit           fire;
        bit           seen;
        int           v;
        if (!clr_hit) clear_all(3'b111);
        fire = cw[10] && !cw[9];
        if (err)                     v = 0;
        else if (!cw[6])             v = 1;
        else if (len == 4 && !cw[7]) v = 2;
        else if (len == 16)          v = 3;
        else                         v = 0;
        er = model_rsp;
        if (fire && v == 2) begin
            er = '0;
            for (int i = 0; i < 4; i++) er[31-8*i -: 8] = base + 8'(i);
        end else if (fire && v == 3) begin
            for (int w = 0; w < 4; w++)
                for (int i = 0; i < 4; i++)
                    er[w*32 + 31 - 8*i -: 8] = base + 8'(4*w + i);
            er[96] = 1'b0;
        end
        nb = '0;
        if (fire) nb = (v >= 2) ? 3'b001 : (v == 1) ? 3'b010 : 3'b100;
        e.st  = (clr_hit ? 3'b000 : model_st) | nb;
        e.rsp = er;
        e.cw  = cw & ~EN;
        e.tag = tag;
        if (cw[10]) q.push_back(e);
        model_st  = e.st;
        model_rsp = er;

        arg_we = 1'b1; arg_wdata = arg;
        @(negedge clk);
        arg_we = 1'b0;
        cw_we = 1'b1; cw_wdata = cw;
        @(negedge clk);
        cw_we = 1'b0;

        if (!fire) begin
            seen = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (card_req) seen = 1'b1;
                @(negedge clk);
            end
            check(!seen, {tag, " R6 no request"}, 128'(seen), 128'(0));
            check(cmd_word === (cw & ~EN), {tag, " R6 stored word"}, 128'(cmd_word),
                  128'(cw & ~EN));
            check(status === model_st, {tag, " R6 status untouched"}, 128'(status),
                  128'(model_st));
            return;
        end

        seen = 1'b0;
        for (int i = 0; i < 20 && !seen; i++) begin
            if (card_req) seen = 1'b1;
            else @(negedge clk);
        end
        check(seen, {tag, " R1 request raised"}, 128'(seen), 128'(1));
        check(card_index === cw[5:0] && card_arg === arg, {tag, " R1 index/arg"},
              128'({card_index, card_arg}), 128'({cw[5:0], arg}));

        card_ack = 1'b1; card_err = err; card_len = 5'(len);
        if (clr_hit && (err || len == 0)) begin clr_we = 1'b1; clr_bits = 3'b111; end
        @(negedge clk);
        card_ack = 1'b0; card_err = 1'b0; card_len = '0;
        clr_we = 1'b0; clr_bits = '0;
        if (!err) begin
            for (int i = 0; i < len; i++) begin
                card_byte_vld = 1'b1; card_byte = base + 8'(i);
                if (poke && i == 0) begin cw_we = 1'b1; cw_wdata = EN | RSP | 11'h3F; end
                if (clr_hit && i == len - 1) begin clr_we = 1'b1; clr_bits = 3'b111; end
                @(negedge clk);
                cw_we = 1'b0; clr_we = 1'b0; clr_bits = '0;
            end
            card_byte_vld = 1'b0; card_byte = '0;
        end
        @(negedge clk);
        @(negedge clk);
        if (poke) begin
            seen = 1'b0;
            for (int i = 0; i < 4; i++) begin
                if (card_req || cmd_active) seen = 1'b1;
                @(negedge clk);
            end
            check(!seen, {tag, " R8 write while busy ignored"}, 128'(seen), 128'(0));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11
        check(status === 3'b0 && cmd_active === 1'b0 && card_req === 1'b0,
              "R11 reset flags", 128'({status, cmd_active, card_req}), 128'(0));
        check(resp_words === '0 && cmd_word === '0, "R11 reset registers",
              resp_words | 128'(cmd_word), 128'(0));

        run_cmd(RSP | 11'd5, 32'h1, 1'b0, 0, 8'h0, 1'b0, 1'b0, "R1 no enable");
        run_cmd(EN | RSP | 11'd17, 32'hA5A5_0001, 1'b0, 4, 8'h11, 1'b0, 1'b0, "R3 short");
        run_cmd(EN | RSP | LNG | 11'd2, 32'h0000_1234, 1'b0, 16, 8'h20, 1'b0, 1'b0, "R4 long");
        run_cmd(EN | RSP | 11'd9, 32'hFFFF_0000, 1'b0, 16, 8'h81, 1'b0, 1'b0,
                "R4 sixteen without long");
        run_cmd(EN | 11'd0, 32'h0, 1'b0, 0, 8'h0, 1'b0, 1'b0, "R2 no response len0");
        run_cmd(EN | 11'd7, 32'hDEAD_BEEF, 1'b0, 4, 8'h55, 1'b0, 1'b0, "R2 bytes ignored");
        run_cmd(EN | RSP | 11'd8, 32'h2, 1'b0, 0, 8'h0, 1'b0, 1'b0, "R5 zero bytes");
        run_cmd(EN | RSP | LNG | 11'd3, 32'h3, 1'b0, 4, 8'h61, 1'b0, 1'b0, "R5 long got four");
        run_cmd(EN | RSP | 11'd12, 32'h4, 1'b0, 7, 8'h71, 1'b0, 1'b0, "R5 odd length");
        run_cmd(EN | RSP | 11'd13, 32'h5, 1'b1, 4, 8'h0, 1'b0, 1'b0, "R5 error wanted");
        run_cmd(EN | 11'd14, 32'h6, 1'b1, 0, 8'h0, 1'b0, 1'b0, "R5 error no response");
        run_cmd(EN | PEND | RSP | 11'd15, 32'h7, 1'b0, 0, 8'h0, 1'b0, 1'b0, "R6 pending");
        run_cmd(EN | RSP | 11'd18, 32'h8, 1'b0, 4, 8'hC1, 1'b1, 1'b0, "R8 busy write");
        run_cmd(EN | RSP | 11'd19, 32'h9, 1'b0, 4, 8'hD1, 1'b0, 1'b1, "R9 clear collision");

        // R9: partial clear keeps the other flags
        clear_all(3'b010);
        check(status === model_st, "R9 partial clear", 128'(status), 128'(model_st));
        clear_all(3'b001);
        check(status === 3'b000, "R9 clear to zero", 128'(status), 128'(0));
        check(q.size() == 0, "R10 every command completed", 128'(q.size()), 128'(0));

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule